// File: doc/BRIEF.md
# Synchronous Reset-Response Sequence Generator

This block sends a fixed 32-bit identification word on a shared open-drain serial data line. The word is sent when the host pulses the reset line while the device is selected. The block runs on the chip's core clock and samples the serial clock, chip select, reset line and write-busy flag as ordinary inputs.

A rising edge on the reset line arms the block, but only if chip select is low and no internal write cycle is in progress. Once the reset pulse ends, the first bit goes on the line. Each falling edge of the serial clock after that moves on to the next bit, most significant first. The falling edge that follows the last bit releases the line.

The block drives a data value and an output enable for the pad. It also drives an ownership flag that tells the command interface to ignore bus activity while a sequence is armed or running. Raising chip select ends a sequence at once. All other command processing is handled elsewhere.

Top module: `rr_seq_gen`

## Requirements
- R1: A rising edge of `rr_req` sampled while `cs_n` is 0 and `wr_busy` is 0 arms the block, and `seq_active` reads 1 from the next cycle on.
- R2: Once armed, the first cycle in which `rr_req` is sampled low starts shifting. From the next cycle on, `sda_oe` is 1 and `sda_out` carries bit 31 of the identification word.
- R3: Each sampled falling edge of `sclk` (1 in one cycle, 0 in the next) moves the output on by one bit, most significant first, so exactly the 32 bits of `ID_WORD` appear in order.
- R4: The falling edge of `sclk` sampled while bit 0 is on the line ends the sequence, and `sda_oe` and `seq_active` read 0 from the next cycle on.
- R5: A rising edge of `rr_req` sampled while `wr_busy` is 1 is ignored, even if `wr_busy` clears before `rr_req` falls.
- R6: While `cs_n` is 1, `sda_oe` and `seq_active` are 0 in the same cycle. An armed or running sequence is dropped and does not resume when `cs_n` returns low.
- R7: A rising edge of `rr_req` sampled while `cs_n` is 1 starts nothing.
- R8: Further activity on `rr_req` while a sequence is shifting has no effect on the output stream.
- R9: After reset, and whenever `sda_oe` is 0, `sda_out` is 1 (released), and `sda_oe` and `seq_active` are 0 until a sequence starts.
- R10: `sclk` rising edges and `sclk` held at a steady level do not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rr_req | input | 1 | Reset-response request line, active high pulse |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| wr_busy | input | 1 | High while an internal write cycle is in progress |
| sda_out | output | 1 | Data value for the pad, 1 when released |
| sda_oe | output | 1 | Pad output enable |
| seq_active | output | 1 | Block owns the data line; command logic stays quiet |

## Verification
Every input is sampled at a core clock edge, so arming, the first bit, each bit advance and the final release all appear one clock after the edge that samples the causing input. The one exception is chip select, which gates `sda_oe` and `seq_active` in the same cycle. The reference model in the bench updates on the same edge the design uses. The bench compares all three outputs at the following falling edge of `clk`, after registers settle and before new stimulus is applied, and it collects the 32 bits seen just before each serial-clock fall to match them against the identification word.

// File: rtl/rr_seq_gen.sv
module rr_seq_gen #(
  parameter int                 ID_BITS = 32,
  parameter logic [ID_BITS-1:0] ID_WORD = 32'hA2C5_1E93
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rr_req,
  input  logic sclk,
  input  logic wr_busy,
  output logic sda_out,
  output logic sda_oe,
  output logic seq_active
);

  localparam int IDX_W = $clog2(ID_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SHIFT} st_t;

  st_t                state;
  logic               req_q;
  logic               sclk_q;
  logic [IDX_W-1:0]   bit_idx;
  logic [ID_BITS-1:0] shreg;

  wire req_rise  = rr_req & ~req_q;
  wire sclk_fall = sclk_q & ~sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      req_q   <= 1'b0;
      sclk_q  <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      req_q  <= rr_req;
      sclk_q <= sclk;
      if (cs_n) begin
        state   <= ST_IDLE;
        bit_idx <= '0;
      end else begin
        unique case (state)
          ST_IDLE:
            if (req_rise && !wr_busy) state <= ST_ARMED;
          ST_ARMED:
            if (!rr_req) begin
              state   <= ST_SHIFT;
              shreg   <= ID_WORD;
              bit_idx <= '0;
            end
          ST_SHIFT:
            if (sclk_fall) begin
              if (bit_idx == LAST_IDX) begin
                state   <= ST_IDLE;
                bit_idx <= '0;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                shreg   <= {shreg[ID_BITS-2:0], 1'b0};
              end
            end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe     = (state == ST_SHIFT) & ~cs_n;
  assign sda_out    = sda_oe ? shreg[ID_BITS-1] : 1'b1;
  assign seq_active = (state != ST_IDLE) & ~cs_n;

endmodule

// File: rtl/rr_seq_gen_chk.sv
module rr_seq_gen_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rr_req,
  input logic             wr_busy,
  input logic             sda_out,
  input logic             sda_oe,
  input logic             seq_active,
  input logic [IDX_W-1:0] bit_idx
);

  // R1
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_active) |-> ($past(rr_req) && !$past(wr_busy) && !$past(cs_n)));

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_busy) && !$past(seq_active)) |-> !seq_active);

  // R6
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sda_oe && !seq_active));

  // R7
  no_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !sda_oe);

  // R9
  released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> sda_out);

  // R10
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && $past(sda_oe)) |->
      (bit_idx == $past(bit_idx) || bit_idx == $past(bit_idx) + 1'b1));

endmodule

bind rr_seq_gen rr_seq_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rr_req(rr_req), .wr_busy(wr_busy),
  .sda_out(sda_out), .sda_oe(sda_oe), .seq_active(seq_active), .bit_idx(bit_idx)
);

// File: tb/rr_seq_gen_test.sv
module rr_seq_gen_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] ID = 32'h5C3B_E186;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rr_req = 1'b0, sclk = 1'b0, wr_busy = 1'b0;
  logic sda_out, sda_oe, seq_active;

  int vec = 0, bad = 0;
  string tag = "R9";

  rr_seq_gen #(.ID_BITS(32), .ID_WORD(ID)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rr_req(rr_req), .sclk(sclk),
    .wr_busy(wr_busy), .sda_out(sda_out), .sda_oe(sda_oe), .seq_active(seq_active)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: 0 idle, 1 armed, 2 shifting
  int   m_phase = 0;
  bit   m_bits[$];
  logic m_preq = 1'b0, m_psclk = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_bits = {}; m_preq = 1'b0; m_psclk = 1'b0;
    end else begin
      if (cs_n) begin
        m_phase = 0; m_bits = {};
      end else if (m_phase == 0) begin
        if (rr_req && !m_preq && !wr_busy) m_phase = 1;
      end else if (m_phase == 1) begin
        if (!rr_req) begin
          m_bits = {};
          for (int k = 31; k >= 0; k--) m_bits.push_back(ID[k]);
          m_phase = 2;
        end
      end else begin
        if (m_psclk && !sclk) begin
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) m_phase = 0;
        end
      end
      m_preq = rr_req; m_psclk = sclk;
    end
  end

  task automatic chk(string t, string what, logic got, logic exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_oe, e_act, e_out;
    e_oe  = (m_phase == 2) && !cs_n;
    e_act = (m_phase != 0) && !cs_n;
    e_out = e_oe ? m_bits[0] : 1'b1;
    chk(tag, "sda_oe", sda_oe, e_oe);
    chk(tag, "seq_active", seq_active, e_act);
    chk(tag, "sda_out", sda_out, e_out);
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_req(int len);
    rr_req = 1'b1; step(len); rr_req = 1'b0; step(1);
  endtask

  task automatic clock_bits(int n, int hi, int lo, output logic [31:0] word);
    word = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; step(hi);
      word = {word[30:0], sda_out};
      sclk = 1'b0; step(lo);
    end
  endtask

  initial begin
    logic [31:0] w;
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    tag = "R9"; step(3); rst_n = 1'b1; step(2);

    tag = "R1"; cs_n = 1'b0; step(2); pulse_req(3);
    tag = "R2"; step(2);
    tag = "R3"; clock_bits(32, 2, 2, w);
    vec++;
    if (w !== ID) begin bad++; $display("FAIL R3 word: got %h expected %h", w, ID); end
    tag = "R4"; step(4);
    vec++;
    if (sda_oe !== 1'b0) begin bad++; $display("FAIL R4 release: got %b expected 0", sda_oe); end

    tag = "R5"; wr_busy = 1'b1; rr_req = 1'b1; step(2); wr_busy = 1'b0; step(2);
    rr_req = 1'b0; step(2); clock_bits(4, 1, 1, w);
    vec++;
    if (seq_active !== 1'b0) begin bad++; $display("FAIL R5 busy start: got %b expected 0", seq_active); end

    tag = "R7"; cs_n = 1'b1; pulse_req(2); cs_n = 1'b0; step(2); clock_bits(3, 1, 1, w);

    tag = "R6"; pulse_req(2); clock_bits(10, 1, 2, w);
    cs_n = 1'b1; #1;
    vec++;
    if (sda_oe !== 1'b0 || seq_active !== 1'b0) begin
      bad++; $display("FAIL R6 same-cycle drop: got %b%b expected 00", sda_oe, seq_active);
    end
    step(2); cs_n = 1'b0; step(1); clock_bits(5, 1, 1, w);
    rr_req = 1'b1; step(2); cs_n = 1'b1; step(1); rr_req = 1'b0; step(1);
    cs_n = 1'b0; step(2);

    tag = "R8"; pulse_req(4);
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b1; rr_req = i[0]; step(1);
      w = {w[30:0], sda_out};
      sclk = 1'b0; step(1);
    end
    rr_req = 1'b0; step(1);
    vec++;
    if (w !== ID) begin bad++; $display("FAIL R8 word: got %h expected %h", w, ID); end

    tag = "R10"; pulse_req(1);
    sclk = 1'b1; step(6); sclk = 1'b0; step(6);
    clock_bits(31, 3, 1, w);
    step(3);
    cs_n = 1'b1; step(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule